// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a processor's virtual address into a physical address. Pages are 1 KB, so the low 10 bits of an address are the in-page offset and are carried across unchanged. Only the upper bits change: a 5-bit virtual page number is mapped to a 3-bit physical frame number. Recent mappings sit in a small fully associative translation buffer. When a lookup misses, the block reads the mapping itself from a single-level table in physical memory. The table's start address comes from a base register that software writes.

Each request carries an access type. Every accepted request ends with a one-cycle completion pulse that brings the physical address and a status. A table entry holds a valid flag, a rights field and a frame number. An entry that is not valid yields a page fault. An access that its rights do not allow yields a protection fault. Only one table read can be in flight at a time, so requests are held off while it is pending. A flush input empties the buffer. A write to the base register also empties it, so that mappings from a previous table are never reused.

Top module: `pagexlat_unit`

## Requirements
- R1: The low 10 bits of `paddr` equal the low 10 bits of the accepted `req_vaddr` whenever `status` is OK.
- R2: On a miss, one table read is issued at `mem_addr` = base register + virtual page number (bits 14:10 of `req_vaddr`), with one entry per address. A valid entry's frame number (`mem_rdata[2:0]`) becomes `paddr[12:10]`.
- R3: An entry whose valid flag (`mem_rdata[5]`) is 0 completes with `status` = 01 (page fault) and `paddr` = 0.
- R4: The rights field is `mem_rdata[4:3]`: 00 read-only, 01 read/write, 10 executable, 11 no access. Access types are 00 load, 01 store, 10 fetch and 11 reserved. Loads are allowed by 00, 01 and 10. Stores are allowed only by 01. Fetches are allowed only by 10. The reserved type is never allowed. A disallowed access completes with `status` = 10 (protection fault) and `paddr` = 0. The same rule applies on buffer hits.
- R5: A request whose page is in the buffer completes in the cycle after acceptance and issues no table read.
- R6: A miss issues exactly one single-cycle `mem_req`.
- R7: A mapping whose entry is not valid is not installed, so a repeat access reads the table again.
- R8: The buffer has 8 entries and replaces them in round-robin order. After 8 distinct pages are installed, the next install evicts the oldest of them.
- R9: A `flush` pulse empties the buffer, so every following access misses once.
- R10: Writing the base register empties the buffer, and later misses read the new table.
- R11: Every accepted request produces exactly one one-cycle `done` pulse.
- R12: `req_ready` stays low from the cycle after a miss is accepted until its completion.
- R13: A flush or base write that arrives while a table read is pending lets that request complete normally but prevents its mapping from being installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 15 | Virtual address |
| req_acc | input | 2 | Access type |
| done | output | 1 | Completion pulse |
| paddr | output | 13 | Physical address (0 on fault) |
| status | output | 2 | 00 OK, 01 page fault, 10 protection fault |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 13 | Table entry address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 6 | Table entry {valid, rights[1:0], frame[2:0]} |
| flush | input | 1 | Empty the translation buffer |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 13 | New table base address |

## Verification
If the buffer kept a stale or duplicate entry, the fault shows at the ports on the very next access to that page: the physical frame is wrong, or a table read appears when none was expected or is missing when one was. If the replacement pointer were wrong, the fault appears only after a ninth distinct page is installed, as a miss or hit on the wrong page. If the walk sequencer's state were wrong, `req_ready` would stay low, or `done` would be missing or repeated, within a few cycles of the miss.

// File: rtl/pagexlat_pkg.sv
package pagexlat_pkg;

    localparam int OFF_W = 10;
    localparam int VPN_W = 5;
    localparam int PPN_W = 3;
    localparam int VA_W  = OFF_W + VPN_W;
    localparam int PA_W  = OFF_W + PPN_W;

    typedef enum logic [1:0] {ACC_LOAD, ACC_STORE, ACC_FETCH, ACC_RSVD} acc_e;
    typedef enum logic [1:0] {RT_RO, RT_RW, RT_EX, RT_NONE} rights_e;
    typedef enum logic [1:0] {ST_OK, ST_PAGE, ST_PROT, ST_RSVD} status_e;
    typedef enum logic [1:0] {WK_IDLE, WK_REQ, WK_WAIT} wk_state_e;

    typedef struct packed {
        logic               valid;
        rights_e            rights;
        logic [PPN_W-1:0]   ppn;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);

    function automatic logic access_ok(rights_e r, acc_e a);
        case (r)
            RT_RO:   return a == ACC_LOAD;
            RT_RW:   return (a == ACC_LOAD) || (a == ACC_STORE);
            RT_EX:   return (a == ACC_LOAD) || (a == ACC_FETCH);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pagexlat_tlb.sv
module pagexlat_tlb
    import pagexlat_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic [VPN_W-1:0] lk_vpn_i,
    output logic             hit_o,
    output logic [PPN_W-1:0] hit_ppn_o,
    output rights_e          hit_rights_o,
    input  logic             ins_en_i,
    input  logic [VPN_W-1:0] ins_vpn_i,
    input  logic [PPN_W-1:0] ins_ppn_i,
    input  rights_e          ins_rights_i
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        rights_e          rights;
    } ent_t;

    ent_t             ent [N];
    logic [N-1:0]     match;
    logic [N-1:0]     valid_vec;
    logic [IDX_W-1:0] rr_ptr;
    logic [1:0]       rights_acc;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g]     = ent[g].valid && (ent[g].vpn == lk_vpn_i);
        assign valid_vec[g] = ent[g].valid;
    end

    always_comb begin
        hit_o      = |match;
        hit_ppn_o  = '0;
        rights_acc = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                hit_ppn_o  = hit_ppn_o | ent[i].ppn;
                rights_acc = rights_acc | ent[i].rights;
            end
        end
        hit_rights_o = rights_e'(rights_acc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent[i] <= '0;
            rr_ptr <= '0;
        end else if (flush_i) begin
            for (int i = 0; i < N; i++) ent[i].valid <= 1'b0;
        end else if (ins_en_i) begin
            ent[rr_ptr] <= '{valid: 1'b1, vpn: ins_vpn_i, ppn: ins_ppn_i, rights: ins_rights_i};
            rr_ptr      <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));  // R5

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (valid_vec == '0));  // R9

endmodule

// File: rtl/pagexlat_walker.sv
module pagexlat_walker
    import pagexlat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic abort_i,
    input  logic mem_rvalid_i,
    output logic ready_o,
    output logic mem_req_o,
    output logic rsp_o,
    output logic keep_o
);
    wk_state_e state;
    logic      stale;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WK_IDLE;
            stale <= 1'b0;
        end else begin
            case (state)
                WK_IDLE: begin
                    if (start_i) begin
                        state <= WK_REQ;
                        stale <= abort_i;
                    end
                end
                WK_REQ: begin
                    state <= WK_WAIT;
                    if (abort_i) stale <= 1'b1;
                end
                WK_WAIT: begin
                    if (abort_i) stale <= 1'b1;
                    if (mem_rvalid_i) state <= WK_IDLE;
                end
                default: state <= WK_IDLE;
            endcase
        end
    end

    assign ready_o   = (state == WK_IDLE);
    assign mem_req_o = (state == WK_REQ);
    assign rsp_o     = (state == WK_WAIT) && mem_rvalid_i;
    assign keep_o    = rsp_o && !stale && !abort_i;

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |=> !mem_req_o);  // R6

    AST_RSP_REOPENS: assert property (@(posedge clk) disable iff (rst)
        rsp_o |=> ready_o);  // R12

    AST_START_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (start_i && ready_o) |=> !ready_o);  // R12

endmodule

// File: rtl/pagexlat_unit.sv
module pagexlat_unit
    import pagexlat_pkg::*;
#(
    parameter int TLB_N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    output logic              done,
    output logic [PA_W-1:0]   paddr,
    output logic [1:0]        status,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [PTE_W-1:0]  mem_rdata,
    input  logic              flush,
    input  logic              base_we,
    input  logic [PA_W-1:0]   base_wdata
);
    logic [PA_W-1:0]  base_q;
    logic [VPN_W-1:0] pend_vpn;
    logic [OFF_W-1:0] pend_off;
    acc_e             pend_acc;

    logic             accept;
    logic             hit;
    logic [PPN_W-1:0] hit_ppn;
    rights_e          hit_rights;
    logic             start;
    logic             abort;
    logic             rsp;
    logic             keep;
    pte_t             pte;
    acc_e             cur_acc;

    logic             done_q;
    logic [PA_W-1:0]  paddr_q;
    status_e          status_q;

    assign cur_acc = acc_e'(req_acc);
    assign accept  = req_valid && req_ready;
    assign start   = accept && !hit;
    assign abort   = flush || base_we;
    assign pte     = pte_t'(mem_rdata);

    pagexlat_tlb #(.N(TLB_N)) u_tlb (
        .clk          (clk),
        .rst          (rst),
        .flush_i      (abort),
        .lk_vpn_i     (req_vaddr[VA_W-1:OFF_W]),
        .hit_o        (hit),
        .hit_ppn_o    (hit_ppn),
        .hit_rights_o (hit_rights),
        .ins_en_i     (keep && pte.valid),
        .ins_vpn_i    (pend_vpn),
        .ins_ppn_i    (pte.ppn),
        .ins_rights_i (pte.rights)
    );

    pagexlat_walker u_walk (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .abort_i      (abort),
        .mem_rvalid_i (mem_rvalid),
        .ready_o      (req_ready),
        .mem_req_o    (mem_req),
        .rsp_o        (rsp),
        .keep_o       (keep)
    );

    assign mem_addr = base_q + {{(PA_W-VPN_W){1'b0}}, pend_vpn};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            pend_vpn <= '0;
            pend_off <= '0;
            pend_acc <= ACC_LOAD;
            done_q   <= 1'b0;
            paddr_q  <= '0;
            status_q <= ST_OK;
        end else begin
            done_q <= 1'b0;
            if (base_we) base_q <= base_wdata;
            if (start) begin
                pend_vpn <= req_vaddr[VA_W-1:OFF_W];
                pend_off <= req_vaddr[OFF_W-1:0];
                pend_acc <= cur_acc;
            end
            if (accept && hit) begin
                done_q <= 1'b1;
                if (access_ok(hit_rights, cur_acc)) begin
                    status_q <= ST_OK;
                    paddr_q  <= {hit_ppn, req_vaddr[OFF_W-1:0]};
                end else begin
                    status_q <= ST_PROT;
                    paddr_q  <= '0;
                end
            end else if (rsp) begin
                done_q <= 1'b1;
                if (!pte.valid) begin
                    status_q <= ST_PAGE;
                    paddr_q  <= '0;
                end else if (!access_ok(pte.rights, pend_acc)) begin
                    status_q <= ST_PROT;
                    paddr_q  <= '0;
                end else begin
                    status_q <= ST_OK;
                    paddr_q  <= {pte.ppn, pend_off};
                end
            end
        end
    end

    assign done   = done_q;
    assign paddr  = paddr_q;
    assign status = status_q;

    AST_ACCEPT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        accept |=> (done_q || mem_req));  // R11

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (done_q && status_q != ST_OK) |-> (paddr_q == '0));  // R3

    AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (rst)
        (accept && hit) |=> !mem_req);  // R5

endmodule

// File: tb/pagexlat_unit_test.sv
module pagexlat_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int BASE_A = 13'h100;
    localparam int BASE_B = 13'h400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [14:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        done;
    logic [12:0] paddr;
    logic [1:0]  status;
    logic        mem_req;
    logic [12:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [5:0]  mem_rdata = '0;
    logic        flush = 1'b0;
    logic        base_we = 1'b0;
    logic [12:0] base_wdata = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int walks = 0;
    int model_base = 0;

    logic [5:0] mem [0:8191];
    logic       rv1 = 1'b0;
    logic [5:0] rd1 = '0;

    typedef struct {
        logic [12:0] pa;
        logic [1:0]  st;
        bit          is_hit;
        int          acc_cyc;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    pagexlat_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .done(done), .paddr(paddr),
        .status(status), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .flush(flush),
        .base_we(base_we), .base_wdata(base_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) walks <= walks + 1;
        rv1        <= mem_req;
        rd1        <= mem[mem_addr];
        mem_rvalid <= rv1;
        mem_rdata  <= rd1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit allowed(input logic [1:0] r, input logic [1:0] a);
        if (a == 2'd3) return 0;
        if (r == 2'd1) return (a == 2'd0) || (a == 2'd1);
        if (r == 2'd0) return a == 2'd0;
        if (r == 2'd2) return (a == 2'd0) || (a == 2'd2);
        return 0;
    endfunction

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                if (sbq.size() == 0) begin
                    check(0, "R11 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(paddr == e.pa && status == e.st, e.tag,
                          {status, paddr}, {e.st, e.pa});
                    if (e.is_hit)
                        check(cyc - e.acc_cyc == 0, "R5 hit latency", cyc - e.acc_cyc, 0);
                end
            end
        end
    end

    task automatic xl(input logic [4:0] vpn, input logic [9:0] off, input logic [1:0] acc,
                      input int exp_walk, input string tag);
        exp_t e;
        logic [5:0] ent;
        int w0;
        ent = mem[13'(model_base + int'(vpn))];
        if (!ent[5]) begin
            e.pa = '0; e.st = 2'b01;
        end else if (!allowed(ent[4:3], acc)) begin
            e.pa = '0; e.st = 2'b10;
        end else begin
            e.pa = {ent[2:0], off}; e.st = 2'b00;
        end
        e.is_hit = (exp_walk == 0);
        e.tag = tag;
        w0 = walks;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {vpn, off};
        req_acc   = acc;
        e.acc_cyc = cyc + 1;
        sbq.push_back(e);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_walk != 0) check(!req_ready, "R12 ready low during walk", req_ready, 0);
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
        check(walks - w0 == exp_walk, "R6 walk count", walks - w0, exp_walk);
    endtask

    task automatic set_base(input int b);
        @(negedge clk);
        base_we = 1'b1; base_wdata = 13'(b);
        @(negedge clk);
        base_we = 1'b0;
        model_base = b;
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8192; i++) mem[i] = '0;
        for (int v = 0; v < 32; v++) begin
            mem[BASE_A + v] = {(v != 7) ? 1'b1 : 1'b0, 2'(v % 4), 3'((v * 3 + 1) % 8)};
            mem[BASE_B + v] = {1'b1, 2'b01, 3'((v + 5) % 8)};
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1 && done == 0 && mem_req == 0, "R11 reset state",
              {req_ready, done, mem_req}, 3'b100);
        set_base(BASE_A);

        xl(5'd5, 10'h3A5, 2'd0, 1, "R1 R2 miss translate");
        xl(5'd5, 10'h001, 2'd1, 0, "R5 hit store");
        xl(5'd29, 10'h2F0, 2'd0, 1, "R2 high page");
        xl(5'd0, 10'h010, 2'd0, 1, "R4 ro load");
        xl(5'd0, 10'h011, 2'd1, 0, "R4 ro store hit");
        xl(5'd1, 10'h020, 2'd2, 1, "R4 rw fetch");
        xl(5'd1, 10'h021, 2'd3, 0, "R4 reserved type");
        xl(5'd2, 10'h030, 2'd2, 1, "R4 ex fetch");
        xl(5'd2, 10'h031, 2'd1, 0, "R4 ex store");
        xl(5'd3, 10'h040, 2'd0, 1, "R4 none load");
        xl(5'd7, 10'h050, 2'd0, 1, "R3 invalid");
        xl(5'd7, 10'h051, 2'd0, 1, "R7 invalid not kept");

        pulse_flush();
        xl(5'd5, 10'h0AA, 2'd0, 1, "R9 flush miss");

        pulse_flush();
        for (int v = 8; v < 16; v++) xl(5'(v), 10'(v), 2'd0, 1, "R8 fill");
        xl(5'd16, 10'h016, 2'd0, 1, "R8 ninth");
        for (int v = 9; v < 16; v++) xl(5'(v), 10'(v + 1), 2'd0, 0, "R8 survivors hit");
        xl(5'd8, 10'h008, 2'd0, 1, "R8 oldest evicted");
        xl(5'd10, 10'h00A, 2'd0, 0, "R8 next kept");
        xl(5'd9, 10'h009, 2'd0, 1, "R8 second evicted");

        set_base(BASE_B);
        xl(5'd10, 10'h1C3, 2'd1, 1, "R10 new table");
        xl(5'd10, 10'h1C4, 2'd0, 0, "R10 new table hit");

        fork
            xl(5'd20, 10'h155, 2'd0, 1, "R13 flush mid walk");
            begin
                @(negedge clk);
                @(negedge clk);
                flush = 1'b1;
                @(negedge clk);
                flush = 1'b0;
            end
        join
        xl(5'd20, 10'h156, 2'd0, 1, "R13 not installed");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule